// File: doc/BRIEF.md
# PLL Divider Programming Front End

This block is the digital control front end of an integer-N frequency synthesizer. It collects the divider settings (a 9-bit main count, a 4-bit swallow count, a 6-bit reference count and a prescaler enable) through one of three ports: a three-wire serial bus, a byte-wide bus with per-section write strobes, or static pins. The two bus modes share one 20-bit staging word. A second 20-bit word is loaded from the staging word on a hop strobe, and a select input chooses which of the two words drives the dividers. This lets software prepare the next channel while the current one stays active, then change channel at once.

An 8-bit auxiliary control word carries power-down, immediate-load, data-out routing and monitor-disable flags. In serial mode it has its own shadow, so a partly shifted value never reaches the outputs. All external strobes and the serial clock are brought into a fast system clock through two-flop synchronizers. Each strobe then acts once, on its detected edge.

Top module: `pll_prog_if`

## Requirements
- R1: While rst_ni is low and after it is released, the staging, hop and auxiliary words are zero. All counter and flag outputs read zero outside direct mode.
- R2: mode_direct_i=1 selects direct mode. With mode_direct_i=0, mode_serial_i=1 selects serial mode and mode_serial_i=0 selects byte mode. Byte strobes are ignored outside byte mode, and the serial clock is ignored outside serial mode.
- R3: In serial mode, with swr_i and ewr_i both low, each rising sclk_i shifts sdata_i into the staging word, first bit at the top. The arrival order is: ref[5], ref[4], main[8], main[7], prescaler enable, main[6..0], ref[3..0], swallow[3..0].
- R4: While swr_i is high in serial mode, sclk_i edges leave the staging word unchanged.
- R5: A rising hop_i (serial or byte mode), or a rising swr_i in serial mode, copies the staging word into the hop word.
- R6: In byte mode, the rising edge of each strobe loads one section. m1_wr_i loads pbus_i[7:0] into {prescaler enable, main[6:0]}. m2_wr_i loads pbus_i[3:0] into {ref[5], ref[4], main[8], main[7]}. a_wr_i loads pbus_i[7:0] into {ref[3:0], swallow[3:0]}.
- R7: Outside direct mode, fsel_i=1 drives the outputs from the staging word and fsel_i=0 drives them from the hop word.
- R8: In serial mode with ewr_i high and swr_i low, sclk_i shifts sdata_i into an 8-bit auxiliary shadow, first bit at the top. The staging word is not changed. The shadow becomes active only on the falling edge of ewr_i.
- R9: In byte mode, a rising ewr_i loads pbus_i into the active auxiliary word directly. A falling ewr_i has no effect.
- R10: The active auxiliary bits map as follows: bit 4 to pwr_down_o, bit 3 to cnt_load_o, bit 2 to msel_out_o, bit 1 to pre_out_o, bit 0 to mon_dis_o. Bits 7..5 are reserved. All five outputs are zero while enh_n_i is high or in direct mode.
- R11: In direct mode, main = {2'b00, pbus_i[6:0]}, prescaler enable = pbus_i[7], swallow = dir_a_i and ref = {2'b00, dir_r_i}.
- R12: A strobe held high acts once. Changing pbus_i while a write strobe stays high does not reload the section.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_direct_i | input | 1 | Direct pin mode select |
| mode_serial_i | input | 1 | Serial (1) or byte (0) bus select |
| sclk_i | input | 1 | Serial clock |
| sdata_i | input | 1 | Serial data |
| swr_i | input | 1 | Serial write strobe |
| ewr_i | input | 1 | Auxiliary word write strobe |
| hop_i | input | 1 | Hop strobe, staging to hop word |
| m1_wr_i | input | 1 | Byte write, low main section |
| m2_wr_i | input | 1 | Byte write, upper bits section |
| a_wr_i | input | 1 | Byte write, ref/swallow section |
| pbus_i | input | 8 | Byte bus; direct main and prescaler bits |
| fsel_i | input | 1 | Output source: staging (1) or hop word (0) |
| enh_n_i | input | 1 | Auxiliary flag enable, active low |
| dir_a_i | input | 4 | Direct swallow count |
| dir_r_i | input | 4 | Direct reference count |
| m_o | output | 9 | Main counter value |
| a_o | output | 4 | Swallow counter value |
| r_o | output | 6 | Reference counter value |
| pre_en_o | output | 1 | Prescaler enable bit |
| pwr_down_o | output | 1 | Power-down flag |
| cnt_load_o | output | 1 | Immediate counter load flag |
| msel_out_o | output | 1 | Modulus select to data-out flag |
| pre_out_o | output | 1 | Prescaler output to data-out flag |
| mon_dis_o | output | 1 | Monitor outputs disable flag |

## Verification
The hardest case to reach is a serially shifted auxiliary value that has filled the shadow but has not yet been released. The bench shifts all eight bits with ewr_i held high and checks that the flag outputs still show the old value. It then checks that the staging word was left untouched, and only then drops ewr_i to see the new flags appear. A similar hidden state is a shift while swr_i stays high. The bench exposes it by turning fsel_i to the staging word after the shift.

// File: rtl/pll_prog_pkg.sv
package pll_prog_pkg;
  localparam int WORD_W = 20;
  localparam int AUX_W  = 8;
  localparam int BYTE_W = 8;

  // strobe lanes in the synchronized vector
  localparam int ST_SCLK = 0;
  localparam int ST_SWR  = 1;
  localparam int ST_EWR  = 2;
  localparam int ST_HOP  = 3;
  localparam int ST_M1   = 4;
  localparam int ST_M2   = 5;
  localparam int ST_A    = 6;
  localparam int N_STB   = 7;

  // auxiliary flag bit positions
  localparam int AX_PWR = 4;
  localparam int AX_CNT = 3;
  localparam int AX_MSL = 2;
  localparam int AX_PRE = 1;
  localparam int AX_MON = 0;

  typedef struct packed {
    logic       pre;
    logic [8:0] m;
    logic [5:0] r;
    logic [3:0] a;
  } cnt_cfg_t;

  function automatic cnt_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
    cnt_cfg_t c;
    c.r   = {w[19:18], w[7:4]};
    c.m   = {w[17:16], w[14:8]};
    c.pre = w[15];
    c.a   = w[3:0];
    return c;
  endfunction
endpackage

// File: rtl/pll_prog_sync.sv
module pll_prog_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pll_prog_edge.sv
module pll_prog_edge #(
  parameter int N        = 1,
  parameter int FALL_IDX = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o,
  output logic         fall_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= lvl_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_rise
    assign rise_o[i] = lvl_i[i] & ~prev_q[i];
  end
  assign fall_o = ~lvl_i[FALL_IDX] & prev_q[FALL_IDX];
endmodule

// File: rtl/pll_prog_regs.sv
module pll_prog_regs
  import pll_prog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_i,
  input  logic              par_i,
  input  logic [N_STB-1:0]  rise_i,
  input  logic              ewr_fall_i,
  input  logic              swr_lvl_i,
  input  logic              ewr_lvl_i,
  input  logic              sdata_i,
  input  logic [BYTE_W-1:0] pbus_i,
  output logic [WORD_W-1:0] prim_o,
  output logic [WORD_W-1:0] sec_o,
  output logic [AUX_W-1:0]  aux_o
);
  logic [AUX_W-1:0] shd_q;
  logic shift_ok;

  assign shift_ok = ser_i & rise_i[ST_SCLK] & ~swr_lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prim_o <= '0;
    end else if (shift_ok && !ewr_lvl_i) begin
      prim_o <= {prim_o[WORD_W-2:0], sdata_i};
    end else if (par_i) begin
      if (rise_i[ST_M2]) prim_o[19:16] <= pbus_i[3:0];
      if (rise_i[ST_M1]) prim_o[15:8]  <= pbus_i;
      if (rise_i[ST_A])  prim_o[7:0]   <= pbus_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sec_o <= '0;
    else if (((ser_i | par_i) & rise_i[ST_HOP]) | (ser_i & rise_i[ST_SWR])) sec_o <= prim_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shd_q <= '0;
    else if (shift_ok && ewr_lvl_i) shd_q <= {shd_q[AUX_W-2:0], sdata_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) aux_o <= '0;
    else if (ser_i && ewr_fall_i) aux_o <= shd_q;
    else if (par_i && rise_i[ST_EWR]) aux_o <= pbus_i;
  end
endmodule

// File: rtl/pll_prog_out.sv
module pll_prog_out
  import pll_prog_pkg::*;
(
  input  logic              direct_i,
  input  logic              fsel_i,
  input  logic              enh_n_i,
  input  logic [WORD_W-1:0] prim_i,
  input  logic [WORD_W-1:0] sec_i,
  input  logic [AUX_W-1:0]  aux_i,
  input  logic [BYTE_W-1:0] pbus_i,
  input  logic [3:0]        dir_a_i,
  input  logic [3:0]        dir_r_i,
  output cnt_cfg_t          cfg_o,
  output logic [4:0]        flags_o
);
  logic aux_en;

  always_comb begin
    if (direct_i) begin
      cfg_o.m   = {2'b00, pbus_i[6:0]};
      cfg_o.pre = pbus_i[7];
      cfg_o.a   = dir_a_i;
      cfg_o.r   = {2'b00, dir_r_i};
    end else begin
      cfg_o = word_to_cfg(fsel_i ? prim_i : sec_i);
    end
  end

  assign aux_en  = ~enh_n_i & ~direct_i;
  assign flags_o = aux_en ? {aux_i[AX_PWR], aux_i[AX_CNT], aux_i[AX_MSL],
                             aux_i[AX_PRE], aux_i[AX_MON]} : 5'b0;
endmodule

// File: rtl/pll_prog_if.sv
module pll_prog_if
  import pll_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_direct_i,
  input  logic       mode_serial_i,
  input  logic       sclk_i,
  input  logic       sdata_i,
  input  logic       swr_i,
  input  logic       ewr_i,
  input  logic       hop_i,
  input  logic       m1_wr_i,
  input  logic       m2_wr_i,
  input  logic       a_wr_i,
  input  logic [7:0] pbus_i,
  input  logic       fsel_i,
  input  logic       enh_n_i,
  input  logic [3:0] dir_a_i,
  input  logic [3:0] dir_r_i,
  output logic [8:0] m_o,
  output logic [3:0] a_o,
  output logic [5:0] r_o,
  output logic       pre_en_o,
  output logic       pwr_down_o,
  output logic       cnt_load_o,
  output logic       msel_out_o,
  output logic       pre_out_o,
  output logic       mon_dis_o
);
  localparam int SYN_W = N_STB + 1 + BYTE_W;

  logic [N_STB-1:0]  stb_raw, stb_lvl, stb_rise;
  logic [SYN_W-1:0]  syn_d, syn_q;
  logic              ewr_fall, sdata_s;
  logic [BYTE_W-1:0] pbus_s;
  logic              ser_mode, par_mode;
  logic [WORD_W-1:0] prim_q, sec_q;
  logic [AUX_W-1:0]  aux_q;
  cnt_cfg_t          cfg;
  logic [4:0]        flags;

  assign ser_mode = ~mode_direct_i & mode_serial_i;
  assign par_mode = ~mode_direct_i & ~mode_serial_i;

  always_comb begin
    stb_raw          = '0;
    stb_raw[ST_SCLK] = sclk_i;
    stb_raw[ST_SWR]  = swr_i;
    stb_raw[ST_EWR]  = ewr_i;
    stb_raw[ST_HOP]  = hop_i;
    stb_raw[ST_M1]   = m1_wr_i;
    stb_raw[ST_M2]   = m2_wr_i;
    stb_raw[ST_A]    = a_wr_i;
  end

  // data rides the same synchronizer as its strobes to stay aligned
  assign syn_d = {pbus_i, sdata_i, stb_raw};

  pll_prog_sync #(.W(SYN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (syn_d),
    .q_o   (syn_q)
  );

  assign stb_lvl = syn_q[N_STB-1:0];
  assign sdata_s = syn_q[N_STB];
  assign pbus_s  = syn_q[SYN_W-1:N_STB+1];

  pll_prog_edge #(.N(N_STB), .FALL_IDX(ST_EWR)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (stb_lvl),
    .rise_o(stb_rise),
    .fall_o(ewr_fall)
  );

  pll_prog_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ser_i     (ser_mode),
    .par_i     (par_mode),
    .rise_i    (stb_rise),
    .ewr_fall_i(ewr_fall),
    .swr_lvl_i (stb_lvl[ST_SWR]),
    .ewr_lvl_i (stb_lvl[ST_EWR]),
    .sdata_i   (sdata_s),
    .pbus_i    (pbus_s),
    .prim_o    (prim_q),
    .sec_o     (sec_q),
    .aux_o     (aux_q)
  );

  pll_prog_out u_out (
    .direct_i(mode_direct_i),
    .fsel_i  (fsel_i),
    .enh_n_i (enh_n_i),
    .prim_i  (prim_q),
    .sec_i   (sec_q),
    .aux_i   (aux_q),
    .pbus_i  (pbus_i),
    .dir_a_i (dir_a_i),
    .dir_r_i (dir_r_i),
    .cfg_o   (cfg),
    .flags_o (flags)
  );

  assign m_o        = cfg.m;
  assign a_o        = cfg.a;
  assign r_o        = cfg.r;
  assign pre_en_o   = cfg.pre;
  assign pwr_down_o = flags[4];
  assign cnt_load_o = flags[3];
  assign msel_out_o = flags[2];
  assign pre_out_o  = flags[1];
  assign mon_dis_o  = flags[0];
endmodule

// File: rtl/pll_prog_if_chk.sv
module pll_prog_if_chk
  import pll_prog_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_direct_i,
  input logic              mode_serial_i,
  input logic              enh_n_i,
  input logic [N_STB-1:0]  stb_rise,
  input logic [N_STB-1:0]  stb_lvl,
  input logic              ewr_fall,
  input logic [WORD_W-1:0] prim_q,
  input logic [WORD_W-1:0] sec_q,
  input logic [AUX_W-1:0]  aux_q,
  input logic [8:0]        m_o,
  input logic [5:0]        r_o,
  input logic              pwr_down_o,
  input logic              cnt_load_o,
  input logic              msel_out_o,
  input logic              pre_out_o,
  input logic              mon_dis_o
);
  logic ser, par;
  assign ser = !mode_direct_i && mode_serial_i;
  assign par = !mode_direct_i && !mode_serial_i;

  p_prim_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser && stb_lvl[ST_SWR]) |=> $stable(prim_q));

  p_sec_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(stb_rise[ST_HOP] && !mode_direct_i) && !(ser && stb_rise[ST_SWR])) |=> $stable(sec_q));

  p_sec_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_rise[ST_HOP] && !mode_direct_i) |=> (sec_q == $past(prim_q)));

  p_aux_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(ser && ewr_fall) && !(par && stb_rise[ST_EWR])) |=> $stable(aux_q));

  p_flag_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enh_n_i || mode_direct_i) |->
      !(pwr_down_o || cnt_load_o || msel_out_o || pre_out_o || mon_dis_o));

  p_direct_force_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_direct_i |-> (m_o[8:7] == 2'b00 && r_o[5:4] == 2'b00));
endmodule

bind pll_prog_if pll_prog_if_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_direct_i(mode_direct_i),
  .mode_serial_i(mode_serial_i),
  .enh_n_i      (enh_n_i),
  .stb_rise     (stb_rise),
  .stb_lvl      (stb_lvl),
  .ewr_fall     (ewr_fall),
  .prim_q       (prim_q),
  .sec_q        (sec_q),
  .aux_q        (aux_q),
  .m_o          (m_o),
  .r_o          (r_o),
  .pwr_down_o   (pwr_down_o),
  .cnt_load_o   (cnt_load_o),
  .msel_out_o   (msel_out_o),
  .pre_out_o    (pre_out_o),
  .mon_dis_o    (mon_dis_o)
);

// File: tb/tb_pll_prog_if.sv
module tb_pll_prog_if;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 5;

  // {m1 byte, m2 nibble, a byte, expected {pre, m[8:0], r[5:0], a[3:0]}}
  localparam logic [39:0] VEC [4] = '{
    {8'h85, 4'hB, 8'h3C, 1'b1, 9'h185, 6'h23, 4'hC},
    {8'h7F, 4'h0, 8'hF0, 1'b0, 9'h07F, 6'h0F, 4'h0},
    {8'h01, 4'h5, 8'h0A, 1'b0, 9'h081, 6'h10, 4'hA},
    {8'hFF, 4'hF, 8'hFF, 1'b1, 9'h1FF, 6'h3F, 4'hF}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_direct_i = 1'b0, mode_serial_i = 1'b0;
  logic sclk_i = 1'b0, sdata_i = 1'b0, swr_i = 1'b0, ewr_i = 1'b0, hop_i = 1'b0;
  logic m1_wr_i = 1'b0, m2_wr_i = 1'b0, a_wr_i = 1'b0;
  logic [7:0] pbus_i = 8'h00;
  logic fsel_i = 1'b0, enh_n_i = 1'b0;
  logic [3:0] dir_a_i = 4'h0, dir_r_i = 4'h0;
  logic [8:0] m_o;
  logic [3:0] a_o;
  logic [5:0] r_o;
  logic pre_en_o, pwr_down_o, cnt_load_o, msel_out_o, pre_out_o, mon_dis_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_prog_if dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .mode_direct_i(mode_direct_i), .mode_serial_i(mode_serial_i),
    .sclk_i(sclk_i), .sdata_i(sdata_i), .swr_i(swr_i), .ewr_i(ewr_i), .hop_i(hop_i),
    .m1_wr_i(m1_wr_i), .m2_wr_i(m2_wr_i), .a_wr_i(a_wr_i), .pbus_i(pbus_i),
    .fsel_i(fsel_i), .enh_n_i(enh_n_i), .dir_a_i(dir_a_i), .dir_r_i(dir_r_i),
    .m_o(m_o), .a_o(a_o), .r_o(r_o), .pre_en_o(pre_en_o),
    .pwr_down_o(pwr_down_o), .cnt_load_o(cnt_load_o), .msel_out_o(msel_out_o),
    .pre_out_o(pre_out_o), .mon_dis_o(mon_dis_o)
  );

  function automatic logic [19:0] cfg_of(input logic [19:0] w);
    return {w[15], w[17:16], w[14:8], w[19:18], w[7:4], w[3:0]};
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] outw();
    return {pre_en_o, m_o, r_o, a_o};
  endfunction

  function automatic logic [19:0] flagw();
    return {15'b0, pwr_down_o, cnt_load_o, msel_out_o, pre_out_o, mon_dis_o};
  endfunction

  task automatic strobe(input int id, input logic [7:0] d);
    pbus_i = d;
    wait_n(GAP);
    case (id)
      0: m1_wr_i = 1'b1;
      1: m2_wr_i = 1'b1;
      2: a_wr_i  = 1'b1;
      3: hop_i   = 1'b1;
      4: swr_i   = 1'b1;
      default: ewr_i = 1'b1;
    endcase
    wait_n(GAP);
    m1_wr_i = 1'b0; m2_wr_i = 1'b0; a_wr_i = 1'b0; hop_i = 1'b0; swr_i = 1'b0; ewr_i = 1'b0;
    wait_n(GAP);
  endtask

  task automatic shift_bits(input logic [19:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata_i = w[i];
      wait_n(GAP);
      sclk_i = 1'b1;
      wait_n(GAP);
      sclk_i = 1'b0;
      wait_n(2);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [19:0] prev_exp;
    logic [19:0] w1, w2;
    w1 = 20'hA5C39;
    w2 = 20'h0F0F0;
    prev_exp = 20'h0;

    wait_n(3);
    // R1: reset values
    fsel_i = 1'b1;
    chk("R1 staging during reset", outw(), 20'h0);
    rst_ni = 1'b1;
    wait_n(3);
    chk("R1 staging after reset", outw(), 20'h0);
    fsel_i = 1'b0;
    wait_n(1);
    chk("R1 hop word after reset", outw(), 20'h0);
    chk("R1 flags after reset", flagw(), 20'h0);

    // table walk: byte loads, ping-pong, hop
    for (int i = 0; i < 4; i++) begin
      logic [19:0] e;
      e = VEC[i][19:0];
      strobe(0, VEC[i][39:32]);
      strobe(1, {4'h0, VEC[i][31:28]});
      strobe(2, VEC[i][27:20]);
      fsel_i = 1'b1; wait_n(1);
      chk($sformatf("R6 byte load entry %0d", i), outw(), e);
      fsel_i = 1'b0; wait_n(1);
      chk($sformatf("R7 hop word before hop entry %0d", i), outw(), prev_exp);
      strobe(3, 8'h00);
      chk($sformatf("R5 hop copy entry %0d", i), outw(), e);
      prev_exp = e;
    end

    // serial mode
    mode_serial_i = 1'b1;
    wait_n(GAP);
    shift_bits(w1, 20);
    fsel_i = 1'b1; wait_n(1);
    chk("R3 serial shift order", outw(), cfg_of(w1));
    fsel_i = 1'b0; wait_n(1);
    chk("R7 hop word holds old value", outw(), prev_exp);
    strobe(4, 8'h00);
    chk("R5 swr rise copies", outw(), cfg_of(w1));

    swr_i = 1'b1;
    wait_n(GAP);
    shift_bits(w2, 20);
    swr_i = 1'b0;
    wait_n(GAP);
    fsel_i = 1'b1; wait_n(1);
    chk("R4 shift blocked while swr high", outw(), cfg_of(w1));

    shift_bits(w2, 20);
    fsel_i = 1'b0;
    strobe(3, 8'h00);
    chk("R5 hop copies in serial mode", outw(), cfg_of(w2));

    // R8: serial auxiliary shadow
    ewr_i = 1'b1;
    wait_n(GAP);
    shift_bits(20'h00015, 8);
    chk("R8 flags unchanged before ewr fall", flagw(), 20'h0);
    fsel_i = 1'b1; wait_n(1);
    chk("R8 staging untouched by aux shift", outw(), cfg_of(w2));
    ewr_i = 1'b0;
    wait_n(GAP);
    chk("R8 flags after ewr fall", flagw(), 20'h00015);
    enh_n_i = 1'b1; wait_n(1);
    chk("R10 flags gated by enh_n", flagw(), 20'h0);
    enh_n_i = 1'b0; wait_n(1);

    // R2: byte strobe ignored in serial mode
    strobe(0, 8'hEE);
    chk("R2 byte strobe ignored in serial", outw(), cfg_of(w2));

    // R9: byte-mode auxiliary load
    mode_serial_i = 1'b0;
    wait_n(GAP);
    pbus_i = 8'h0A;
    wait_n(GAP);
    ewr_i = 1'b1;
    wait_n(GAP + 1);
    chk("R9 aux load on ewr rise", flagw(), 20'h0000A);
    ewr_i = 1'b0;
    wait_n(GAP);
    chk("R9 ewr fall no effect", flagw(), 20'h0000A);

    // R2: serial clock ignored in byte mode
    shift_bits(20'hFFFFF, 4);
    chk("R2 sclk ignored in byte mode", outw(), cfg_of(w2));

    // R12: held strobe acts once
    pbus_i = 8'h12;
    wait_n(GAP);
    m1_wr_i = 1'b1;
    wait_n(GAP);
    pbus_i = 8'h34;
    wait_n(GAP + 2);
    m1_wr_i = 1'b0;
    wait_n(GAP);
    chk("R12 held strobe loads once", outw(), cfg_of(20'h012F0));

    // R11: direct mode
    mode_direct_i = 1'b1;
    pbus_i = 8'hFF; dir_a_i = 4'h6; dir_r_i = 4'h9;
    wait_n(2);
    chk("R11 direct values", outw(), {1'b1, 9'h07F, 6'h09, 4'h6});
    chk("R10 flags off in direct", flagw(), 20'h0);
    pbus_i = 8'h00; dir_a_i = 4'hF; dir_r_i = 4'hF;
    wait_n(2);
    chk("R11 direct upper bits zero", outw(), {1'b0, 9'h000, 6'h0F, 4'hF});
    mode_direct_i = 1'b0;
    wait_n(2);
    chk("R10 flags return after direct", flagw(), 20'h0000A);

    // R1: mid-run reset
    rst_ni = 1'b0;
    wait_n(2);
    fsel_i = 1'b1; wait_n(1);
    chk("R1 staging cleared", outw(), 20'h0);
    fsel_i = 1'b0; wait_n(1);
    chk("R1 hop word cleared", outw(), 20'h0);
    chk("R1 flags cleared", flagw(), 20'h0);
    rst_ni = 1'b1;
    wait_n(3);

    finish_run();
  end
endmodule